// File: doc/BRIEF.md
# Triggered Sample Ring Buffer

One digitizer channel's samples enter this block on every clock and land in a circular store that keeps the most recent history. When a trigger arrives, the block picks out a window of samples that began a programmed number of sample periods in the past. It then plays that window out on a valid/ready stream, oldest sample first. The first beat carries a start marker and the last beat an end marker.

Two register inputs, latched when a trigger is accepted, set the look-back latency and the window length. The default depth of 256 entries covers a 5 µs trigger latency at a 32 MHz sample rate (160 samples) with room to spare. Writing never pauses, so history keeps building during a readout. A trigger that arrives while a window is still in flight is dropped and raises a sticky overflow flag, which clears only on reset.

Top module: `trig_ring_buffer`

## Requirements
- R1: A sample is written on every clock. For an accepted trigger at clock edge T with effective latency L, the first beat of the window is the sample that was presented L edges before T.
- R2: A window delivers exactly W effective-length beats of consecutive samples, oldest first. After the last beat, out_valid_o stays low until the next accepted trigger.
- R3: A trigger that arrives while busy_o is high is ignored and does not disturb the window in progress. It sets overflow_o, which stays high until reset.
- R4: If the latency input is below the effective window length, the effective latency is the window length.
- R5: A window length input of 0 is treated as 1.
- R6: out_sow_o is high only on the first beat of a window and out_eow_o only on the last. On a one-beat window both are high.
- R7: While out_valid_o is high and out_ready_i is low, out_data_o, out_sow_o and out_eow_o hold steady. With out_ready_i held high, one beat moves per clock.
- R8: After reset, out_valid_o, busy_o and overflow_o are low.
- R9: Latency and window length are captured when the trigger is accepted. Later changes to those inputs do not affect the window in progress.
- R10: busy_o goes high on the clock after an accepted trigger and stays high until the last beat has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 10 | Digitized sample, written every clock |
| trig_i | input | 1 | Trigger request |
| latency_i | input | 8 | Look-back distance in samples |
| win_len_i | input | 8 | Window length in samples |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Consumer accepts the beat |
| out_data_o | output | 10 | Output sample |
| out_sow_o | output | 1 | First beat of the window |
| out_eow_o | output | 1 | Last beat of the window |
| busy_o | output | 1 | A window is pending or in flight |
| overflow_o | output | 1 | Sticky: a trigger was dropped |

## Verification
The hardest case to reach is a second trigger that lands mid-window and is meant to be dropped. If the consumer drains the window at full rate, the overlap lasts only a few cycles. The bench therefore holds out_ready_i low right after the first trigger, so the window stays parked. While it is parked, the bench fires the second trigger and also changes the latency and length inputs. It then drains the window and checks that the data still follows the first trigger's settings, that no second window appears, and that the overflow flag has latched. Since the input is a running count, any wrong start address or any skipped or repeated slot shows up directly as a wrong value.

// File: rtl/trb_pkg.sv
package trb_pkg;
  typedef enum logic [0:0] {
    RD_IDLE   = 1'b0,
    RD_ACTIVE = 1'b1
  } rd_state_e;
endpackage

// File: rtl/trb_wr_ctrl.sv
module trb_wr_ctrl #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              we_o,
  output logic [ADDR_W-1:0] wptr_o
);
  logic [ADDR_W-1:0] wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wptr_q <= '0;
    else         wptr_q <= wptr_q + ADDR_W'(1);
  end

  assign we_o   = 1'b1;
  assign wptr_o = wptr_q;
endmodule

// File: rtl/trb_mem.sv
module trb_mem #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) store_q[waddr_i] <= wdata_i;
  end

  // read is combinational so the output stage can fetch every cycle
  assign rdata_o = store_q[raddr_i];
endmodule

// File: rtl/trb_rd_ctrl.sv
module trb_rd_ctrl
  import trb_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] wptr_i,
  input  logic [ADDR_W-1:0] latency_i,
  input  logic [ADDR_W-1:0] win_len_i,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sow_o,
  output logic              out_eow_o,
  output logic              busy_o,
  output logic              overflow_o
);
  logic [ADDR_W-1:0] win_eff, lat_eff;
  logic [ADDR_W-1:0] rd_addr_q, left_q;
  logic              first_q;
  logic              valid_q, sow_q, eow_q, ovf_q;
  logic [DATA_W-1:0] data_q;
  rd_state_e         state;
  logic              busy, accept, load;

  assign win_eff = (win_len_i == '0) ? ADDR_W'(1) : win_len_i;
  assign lat_eff = (latency_i < win_eff) ? win_eff : latency_i;

  assign state  = (left_q != '0) ? RD_ACTIVE : RD_IDLE;
  assign busy   = (state == RD_ACTIVE) || valid_q;
  assign accept = trig_i && !busy;
  assign load   = (state == RD_ACTIVE) && (!valid_q || out_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_addr_q <= '0;
      left_q    <= '0;
      first_q   <= 1'b0;
    end else if (accept) begin
      rd_addr_q <= wptr_i - lat_eff;
      left_q    <= win_eff;
      first_q   <= 1'b1;
    end else if (load) begin
      rd_addr_q <= rd_addr_q + ADDR_W'(1);
      left_q    <= left_q - ADDR_W'(1);
      first_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      sow_q   <= 1'b0;
      eow_q   <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= rdata_i;
      sow_q   <= first_q;
      eow_q   <= (left_q == ADDR_W'(1));
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
      sow_q   <= 1'b0;
      eow_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ovf_q <= 1'b0;
    else if (trig_i && busy) ovf_q <= 1'b1;
  end

  assign raddr_o     = rd_addr_q;
  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
  assign out_sow_o   = sow_q;
  assign out_eow_o   = eow_q;
  assign busy_o      = busy;
  assign overflow_o  = ovf_q;

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !out_ready_i |=> valid_q && $stable(data_q) && $stable(sow_q) && $stable(eow_q)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R3
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(trig_i && busy)); // R3
  AST_BUSY_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && !busy |=> busy_o); // R10
  AST_EOW_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && out_ready_i && eow_q |=> !valid_q); // R2
  AST_MARKS_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sow_o || out_eow_o) |-> out_valid_o); // R6
endmodule

// File: rtl/trig_ring_buffer.sv
module trig_ring_buffer #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] latency_i,
  input  logic [ADDR_W-1:0] win_len_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sow_o,
  output logic              out_eow_o,
  output logic              busy_o,
  output logic              overflow_o
);
  logic              we;
  logic [ADDR_W-1:0] wptr, raddr;
  logic [DATA_W-1:0] rdata;

  trb_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_o  (we),
    .wptr_o(wptr)
  );

  trb_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(wptr),
    .wdata_i(sample_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  trb_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .wptr_i     (wptr),
    .latency_i  (latency_i),
    .win_len_i  (win_len_i),
    .raddr_o    (raddr),
    .rdata_i    (rdata),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .out_sow_o  (out_sow_o),
    .out_eow_o  (out_eow_o),
    .busy_o     (busy_o),
    .overflow_o (overflow_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> !out_valid_o && !overflow_o); // R8
endmodule

// File: tb/trig_ring_buffer_bench.sv
module trig_ring_buffer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] sample_i = '0;
  logic       trig_i = 1'b0;
  logic [7:0] latency_i = 8'd20;
  logic [7:0] win_len_i = 8'd16;
  logic       out_valid_o, out_ready_i, out_sow_o, out_eow_o, busy_o, overflow_o;
  logic [9:0] out_data_o;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  logic [9:0] stim = '0;
  logic [9:0] exp_first;
  logic       done = 1'b0;

  trig_ring_buffer u_trig_ring_buffer (.*);

  always #10 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    sample_i = stim;
    stim = stim + 10'd1;
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // drives a one-cycle trigger; returns sample value L edges before it
  task automatic fire(input int lat, input int win);
    int w, l;
    @(negedge clk_i); #1;
    latency_i = 8'(lat); win_len_i = 8'(win);
    w = (win == 0) ? 1 : win;
    l = (lat < w) ? w : lat;
    exp_first = sample_i - 10'(l);
    trig_i = 1'b1;
    @(negedge clk_i); #1;
    trig_i = 1'b0;
    #1 check(busy_o == 1'b1, "R10 busy after trigger", busy_o, 1);
  endtask

  // mode 0: ready high, 1: alternating, 2: ready one cycle in four
  task automatic collect(input int win, input int mode, input string req);
    int         k = 0, g = 0;
    bit         held = 1'b0;
    logic [9:0] held_d = '0;
    while (k < win && g < 3000) begin
      @(negedge clk_i); #1;
      out_ready_i = (mode == 0) ? 1'b1 : (mode == 1) ? g[0] : (g[1:0] == 2'd3);
      #1;
      if (held && out_valid_o)
        check(out_data_o == held_d, "R7 stalled data held", out_data_o, held_d);
      held = 1'b0;
      if (out_valid_o && out_ready_i) begin
        check(out_data_o == exp_first + 10'(k), req, out_data_o, exp_first + 10'(k));
        check(out_sow_o == (k == 0), "R6 start marker", out_sow_o, (k == 0));
        check(out_eow_o == (k == win - 1), "R6 end marker", out_eow_o, (k == win - 1));
        k++;
      end else if (out_valid_o) begin
        held = 1'b1; held_d = out_data_o;
      end
      g++;
    end
    check(k == win, "R2 beat count", k, win);
    idle(3); #2;
    check(out_valid_o == 1'b0, "R2 no extra beats", out_valid_o, 0);
    check(busy_o == 1'b0, "R10 busy clears", busy_o, 0);
  endtask

  task automatic t_reset;
    #2;
    check(out_valid_o == 1'b0, "R8 valid low", out_valid_o, 0);
    check(busy_o == 1'b0, "R8 busy low", busy_o, 0);
    check(overflow_o == 1'b0, "R8 overflow low", overflow_o, 0);
  endtask

  task automatic t_basic;
    out_ready_i = 1'b1;
    fire(20, 16);
    collect(16, 0, "R1 window data latency 20");
    fire(160, 16);
    collect(16, 0, "R1 window data latency 160");
    fire(255, 8);
    collect(8, 0, "R1 window data latency 255");
  endtask

  task automatic t_backpressure;
    fire(40, 12);
    collect(12, 1, "R7 data under alternating ready");
    fire(90, 10);
    collect(10, 2, "R7 data under sparse ready");
  endtask

  task automatic t_clamp;
    fire(4, 16);
    collect(16, 0, "R4 latency clamped to window");
    fire(0, 0);
    collect(1, 0, "R5 zero length gives one beat");
  endtask

  task automatic t_overrun;
    check(overflow_o == 1'b0, "R3 overflow clear before", overflow_o, 0);
    out_ready_i = 1'b0;
    fire(40, 24);
    idle(2); #1;
    latency_i = 8'd7; win_len_i = 8'd3;
    trig_i = 1'b1;
    @(negedge clk_i); #1;
    trig_i = 1'b0;
    #1 check(overflow_o == 1'b1, "R3 overflow set", overflow_o, 1);
    collect(24, 0, "R9 window keeps captured settings");
    check(overflow_o == 1'b1, "R3 overflow sticky", overflow_o, 1);
  endtask

  initial begin
    out_ready_i = 1'b0;
    idle(3);
    t_reset();
    #1 rst_ni = 1'b1;
    idle(300);
    t_basic();
    t_backpressure();
    t_clamp();
    t_overrun();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule